// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Aligner

This block sits between a 32-bit integer datapath and a byte-addressed data memory that has one 32-bit word port. For each access it forms the effective address by adding a sign-extended 16-bit displacement to a base register value. For stores it produces the per-lane byte enables and write data that is already placed on the correct lanes. For loads it takes the word the memory returns and produces a 32-bit value that is extracted and then sign- or zero-extended. It also flags halfword and word accesses whose address is not naturally aligned.

Lanes are numbered big-endian. The lowest byte address within a word carries the most significant byte. Enable bit 3 therefore covers address offset 0, and enable bit 0 covers offset 3. An optional output register stage, selected by a parameter, retimes the request side. Load extraction then follows the registered request, and the returned memory word is used in the cycle the request is presented.

Top module: `be_lane_align`

## Requirements
- R1: `addr_o` equals `base_i` plus `offset_i` sign-extended to 32 bits, with the sum taken modulo 2^32.
- R2: `size_i` is encoded as 0 = byte, 1 = halfword, 2 = word, and 3 is treated as word. Enable bit (3 - k) covers the byte at address offset k. An aligned byte access enables one lane (4'b1000 >> addr[1:0]). An aligned halfword enables 4'b1100 at offset 0 and 4'b0011 at offset 2. An aligned word enables 4'b1111.
- R3: `misalign_o` is 1 for a halfword at an odd address and for a word whose addr[1:0] is not 0. It is never 1 for a byte access.
- R4: A misaligned access drives `be_o` to 4'b0000, so a misaligned store leaves memory unchanged.
- R5: `wdata_o` is the store data replicated over the lanes. A byte access gives four copies of bits [7:0], a halfword gives two copies of bits [15:0], and a word gives the data unchanged.
- R6: A signed byte load returns the byte at the load address, found in lane (3 - addr[1:0]) of `rdata_i`, with its bit 7 copied into bits 31:8.
- R7: An unsigned byte or halfword load returns the value with zeros in all upper bits.
- R8: A halfword load takes `rdata_i[31:16]` at offset 0 and `rdata_i[15:0]` at offset 2. A signed halfword load copies bit 15 into bits 31:16.
- R9: A word load returns `rdata_i` unchanged.
- R10: With the output register enabled (the default), `addr_o`, `be_o`, `wdata_o`, `we_o` and `misalign_o` show the request one clock after it is applied. Reset drives all of them to 0.
- R11: `we_o` follows `store_i` through the same stage as the other request outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output stage |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_i | input | 32 | Base register value |
| offset_i | input | 16 | Signed address displacement |
| size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 or 3 word |
| unsigned_i | input | 1 | 1 selects zero extension for sub-word loads |
| store_i | input | 1 | 1 for a store, 0 for a load |
| wdata_i | input | 32 | Store source register value |
| rdata_i | input | 32 | Word returned by memory for the presented address |
| addr_o | output | 32 | Effective byte address |
| be_o | output | 4 | Lane enables, bit 3 = address offset 0 |
| wdata_o | output | 32 | Lane-replicated store data |
| we_o | output | 1 | Write strobe for the memory |
| misalign_o | output | 1 | Access is not naturally aligned |
| ldata_o | output | 32 | Extracted and extended load result |

## Verification
The case that is hardest to reach is a misaligned store that must have no effect at all. Seen at the ports, that is the same as an ordinary store that happens to hit an unused location. The stimulus therefore first fills a word with known bytes and then issues misaligned word and halfword stores that overlap it. It then reads the word and the overlapped byte back through normal loads, and the memory contents show whether any lane was written. The bench memory is written only from `be_o` and `wdata_o`, so every load result also checks the earlier lane placement, including a displacement that wraps past 2^32 and a negative displacement.

// File: rtl/be_lsa_pkg.sv
package be_lsa_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/lsa_addr_gen.sv
module lsa_addr_gen
  import be_lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic [DATA_W-1:0] base_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  acc_size_e         size_i,
  output logic [DATA_W-1:0] addr_o,
  output logic              misalign_o
);
  logic [DATA_W-1:0] off_ext;

  assign off_ext = {{(DATA_W-OFF_W){offset_i[OFF_W-1]}}, offset_i};
  assign addr_o  = base_i + off_ext;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: misalign_o = 1'b0;
      SZ_HALF: misalign_o = addr_o[0];
      default: misalign_o = |addr_o[1:0];
    endcase
  end
endmodule

// File: rtl/lsa_store_lanes.sv
module lsa_store_lanes
  import be_lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int LANE_AW = $clog2(LANES)
) (
  input  logic [LANE_AW-1:0] addr_lo_i,
  input  acc_size_e          size_i,
  input  logic               misalign_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [LANES-1:0]   be_o,
  output logic [DATA_W-1:0]  wdata_o
);
  logic [LANES-1:0] be_raw;

  // lane i holds address offset LANES-1-i (big-endian)
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int K = LANES - 1 - i;
    always_comb begin
      unique case (size_i)
        SZ_BYTE: be_raw[i] = (addr_lo_i == LANE_AW'(K));
        SZ_HALF: be_raw[i] = (addr_lo_i[LANE_AW-1:1] == (LANE_AW-1)'(K / 2));
        default: be_raw[i] = 1'b1;
      endcase
    end
  end

  assign be_o = misalign_i ? '0 : be_raw;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: wdata_o = {LANES{wdata_i[7:0]}};
      SZ_HALF: wdata_o = {(LANES/2){wdata_i[15:0]}};
      default: wdata_o = wdata_i;
    endcase
  end
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
  import be_lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int HALVES = LANES / 2,
  localparam int LANE_AW = $clog2(LANES)
) (
  input  logic [LANE_AW-1:0] addr_lo_i,
  input  acc_size_e          size_i,
  input  logic               unsigned_i,
  input  logic [DATA_W-1:0]  rdata_i,
  output logic [DATA_W-1:0]  ldata_o
);
  logic [7:0]  lane_b [LANES];
  logic [15:0] lane_h [HALVES];
  logic [LANE_AW-1:0]   b_idx;
  logic [LANE_AW-2:0]   h_idx;
  logic [7:0]  sel_b;
  logic [15:0] sel_h;

  for (genvar i = 0; i < LANES; i++) begin : g_b
    assign lane_b[i] = rdata_i[8*i +: 8];
  end
  for (genvar j = 0; j < HALVES; j++) begin : g_h
    assign lane_h[j] = rdata_i[16*j +: 16];
  end

  assign b_idx = LANE_AW'(LANES - 1) - addr_lo_i;
  assign h_idx = (LANE_AW-1)'(HALVES - 1) - addr_lo_i[LANE_AW-1:1];
  assign sel_b = lane_b[b_idx];
  assign sel_h = lane_h[h_idx];

  always_comb begin
    unique case (size_i)
      SZ_BYTE: ldata_o = {{(DATA_W-8){sel_b[7] & ~unsigned_i}}, sel_b};
      SZ_HALF: ldata_o = {{(DATA_W-16){sel_h[15] & ~unsigned_i}}, sel_h};
      default: ldata_o = rdata_i;
    endcase
  end
endmodule

// File: rtl/be_lane_align.sv
module be_lane_align
  import be_lsa_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int OFF_W   = 16,
  parameter bit OUT_REG = 1'b1,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_AW = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] base_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [1:0]        size_i,
  input  logic              unsigned_i,
  input  logic              store_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] addr_o,
  output logic [LANES-1:0]  be_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              we_o,
  output logic              misalign_o,
  output logic [DATA_W-1:0] ldata_o
);
  acc_size_e         size_c;
  logic [DATA_W-1:0] addr_c;
  logic              mis_c;
  logic [LANES-1:0]  be_c;
  logic [DATA_W-1:0] wd_c;

  acc_size_e         out_size;
  logic              out_uns;

  assign size_c = acc_size_e'(size_i);

  lsa_addr_gen #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_addr (
    .base_i    (base_i),
    .offset_i  (offset_i),
    .size_i    (size_c),
    .addr_o    (addr_c),
    .misalign_o(mis_c)
  );

  lsa_store_lanes #(.DATA_W(DATA_W)) u_st (
    .addr_lo_i (addr_c[LANE_AW-1:0]),
    .size_i    (size_c),
    .misalign_i(mis_c),
    .wdata_i   (wdata_i),
    .be_o      (be_c),
    .wdata_o   (wd_c)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_o     <= '0;
        be_o       <= '0;
        wdata_o    <= '0;
        we_o       <= 1'b0;
        misalign_o <= 1'b0;
        out_size   <= SZ_WORD;
        out_uns    <= 1'b0;
      end else begin
        addr_o     <= addr_c;
        be_o       <= be_c;
        wdata_o    <= wd_c;
        we_o       <= store_i;
        misalign_o <= mis_c;
        out_size   <= size_c;
        out_uns    <= unsigned_i;
      end
    end

    assert_out_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_ni |=> (addr_o == $past(addr_c)) && (be_o == $past(be_c)) && (we_o == $past(store_i)));
  end else begin : g_comb
    assign addr_o     = addr_c;
    assign be_o       = be_c;
    assign wdata_o    = wd_c;
    assign we_o       = store_i;
    assign misalign_o = mis_c;
    assign out_size   = size_c;
    assign out_uns    = unsigned_i;
  end

  lsa_load_extract #(.DATA_W(DATA_W)) u_ld (
    .addr_lo_i (addr_o[LANE_AW-1:0]),
    .size_i    (out_size),
    .unsigned_i(out_uns),
    .rdata_i   (rdata_i),
    .ldata_o   (ldata_o)
  );

  assert_misalign_no_lanes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mis_c |-> (be_c == '0));

  assert_byte_one_lane_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_c == SZ_BYTE) |-> ($countones(be_c) == 1) && !mis_c);

  assert_word_full_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((size_c == SZ_WORD || size_c == SZ_RSVD) && !mis_c) |-> (&be_c) && (addr_c[LANE_AW-1:0] == '0));

  assert_half_even_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((size_c == SZ_HALF) && !mis_c) |-> !addr_c[0] && ($countones(be_c) == 2));

  assert_zero_ext_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_uns && out_size == SZ_BYTE) |-> (ldata_o[DATA_W-1:8] == '0));

  assert_sign_ext_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!out_uns && out_size == SZ_BYTE) |-> (ldata_o[DATA_W-1:8] == {(DATA_W-8){ldata_o[7]}}));
endmodule

// File: tb/tb_be_lane_align.sv
`timescale 1ns/1ps
module tb_be_lane_align;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] base_i = '0;
  logic [15:0] offset_i = '0;
  logic [1:0]  size_i = 2'd2;
  logic        unsigned_i = 1'b0;
  logic        store_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_i;
  logic [31:0] addr_o, wdata_o, ldata_o;
  logic [3:0]  be_o;
  logic        we_o, misalign_o;

  always #2 clk = ~clk;

  be_lane_align dut (
    .clk_i(clk), .rst_ni(rst_ni), .base_i(base_i), .offset_i(offset_i),
    .size_i(size_i), .unsigned_i(unsigned_i), .store_i(store_i),
    .wdata_i(wdata_i), .rdata_i(rdata_i), .addr_o(addr_o), .be_o(be_o),
    .wdata_o(wdata_o), .we_o(we_o), .misalign_o(misalign_o), .ldata_o(ldata_o)
  );

  // behavioural memory, written only from the block's outputs
  logic [31:0] mem [64];
  logic [7:0]  ref_b [256];
  assign rdata_i = mem[addr_o[7:2]];

  always @(negedge clk) begin
    if (rst_ni && we_o) begin
      for (int k = 0; k < 4; k++)
        if (be_o[k]) mem[addr_o[7:2]][8*k +: 8] <= wdata_o[8*k +: 8];
    end
  end

  typedef struct {
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] wd;
    logic        mis;
    logic        we;
    logic        chk_ld;
    logic [31:0] ld;
    string       tag;
  } exp_t;
  exp_t q[$];

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: compares one item per clock, after the output stage updates
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk("R1", {e.tag, " addr"}, addr_o, e.addr);
      chk("R3", {e.tag, " misalign"}, {31'd0, misalign_o}, {31'd0, e.mis});
      chk(e.mis ? "R4" : "R2", {e.tag, " be"}, {28'd0, be_o}, {28'd0, e.be});
      chk("R11", {e.tag, " we"}, {31'd0, we_o}, {31'd0, e.we});
      if (e.we) chk("R5", {e.tag, " wdata"}, wdata_o, e.wd);
      if (e.chk_ld) chk(e.tag, "ldata", ldata_o, e.ld);
    end
  end

  // driver: applies one access and pushes its expected outcome
  task automatic op(input logic [31:0] base, input logic [15:0] off, input logic [1:0] sz,
                    input logic uns, input logic st, input logic [31:0] wd, input string tag);
    exp_t e;
    logic [31:0] ea;
    logic [7:0]  a;
    @(negedge clk);
    base_i = base; offset_i = off; size_i = sz; unsigned_i = uns; store_i = st; wdata_i = wd;
    ea = base + {{16{off[15]}}, off};
    a = ea[7:0];
    e.addr = ea;
    e.we = st;
    e.tag = tag;
    e.mis = (sz == 2'd1) ? ea[0] : (sz == 2'd0) ? 1'b0 : (ea[1:0] != 2'd0);
    e.be = 4'd0;
    for (int k = 0; k < 4; k++) begin
      bit cov;
      cov = (sz == 2'd0) ? (k == ea[1:0]) : (sz == 2'd1) ? ((k / 2) == ea[1]) : 1'b1;
      if (cov && !e.mis) e.be[3-k] = 1'b1;
    end
    e.wd = (sz == 2'd0) ? {4{wd[7:0]}} : (sz == 2'd1) ? {2{wd[15:0]}} : wd;
    e.chk_ld = !st && !e.mis;
    e.ld = '0;
    if (!st && !e.mis) begin
      if (sz == 2'd0) e.ld = uns ? {24'd0, ref_b[a]} : {{24{ref_b[a][7]}}, ref_b[a]};
      else if (sz == 2'd1) e.ld = uns ? {16'd0, ref_b[a], ref_b[8'(a+1)]}
                                      : {{16{ref_b[a][7]}}, ref_b[a], ref_b[8'(a+1)]};
      else e.ld = {ref_b[a], ref_b[8'(a+1)], ref_b[8'(a+2)], ref_b[8'(a+3)]};
    end
    if (st && !e.mis) begin
      if (sz == 2'd0) ref_b[a] = wd[7:0];
      else if (sz == 2'd1) begin ref_b[a] = wd[15:8]; ref_b[8'(a+1)] = wd[7:0]; end
      else for (int k = 0; k < 4; k++) ref_b[8'(a+k)] = wd[31-8*k -: 8];
    end
    q.push_back(e);
  endtask

  initial begin
    for (int w = 0; w < 64; w++) begin
      mem[w] = {8'(w), 8'(w ^ 8'h5A), 8'(~w), 8'(w * 3)};
      for (int k = 0; k < 4; k++) ref_b[4*w+k] = mem[w][31-8*k -: 8];
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10", "reset addr", addr_o, 32'd0);
    chk("R10", "reset be", {28'd0, be_o}, 32'd0);
    chk("R10", "reset wdata", wdata_o, 32'd0);
    chk("R10", "reset we/mis", {30'd0, we_o, misalign_o}, 32'd0);
    rst_ni = 1'b1;

    op(32'h40, 16'h0000, 2'd2, 0, 1, 32'h11223344, "R5 word store");
    op(32'h40, 16'h0000, 2'd2, 0, 0, 32'h0, "R9 word load");
    op(32'h40, 16'h0001, 2'd0, 0, 1, 32'hFFFFFFAB, "R5 byte store");
    op(32'h40, 16'h0001, 2'd0, 0, 0, 32'h0, "R6 signed byte");
    op(32'h40, 16'h0001, 2'd0, 1, 0, 32'h0, "R7 unsigned byte");
    op(32'h40, 16'h0000, 2'd2, 0, 0, 32'h0, "R2 byte lane placement");
    op(32'h40, 16'h0002, 2'd1, 0, 1, 32'h12348001, "R5 half store");
    op(32'h40, 16'h0002, 2'd1, 0, 0, 32'h0, "R8 signed half off2");
    op(32'h40, 16'h0002, 2'd1, 1, 0, 32'h0, "R7 unsigned half");
    op(32'h40, 16'h0000, 2'd1, 0, 0, 32'h0, "R8 half off0");
    op(32'h40, 16'h0003, 2'd0, 0, 0, 32'h0, "R6 byte off3");
    op(32'h40, 16'h0000, 2'd0, 0, 0, 32'h0, "R6 byte off0");
    op(32'h40, 16'h0001, 2'd2, 0, 1, 32'hDEADBEEF, "R3 misaligned word store");
    op(32'h40, 16'h0003, 2'd1, 0, 1, 32'hCAFE5555, "R3 misaligned half store");
    op(32'h40, 16'h0000, 2'd2, 0, 0, 32'h0, "R4 word unchanged");
    op(32'h40, 16'h0003, 2'd0, 1, 0, 32'h0, "R4 byte unchanged");
    op(32'h40, 16'h0001, 2'd1, 0, 0, 32'h0, "R3 misaligned half load");
    op(32'h42, 16'h0000, 2'd2, 0, 0, 32'h0, "R3 misaligned word load");
    op(32'h80, 16'hFFFC, 2'd2, 0, 0, 32'h0, "R1 negative offset");
    op(32'hFFFFFFF0, 16'h0050, 2'd2, 0, 0, 32'h0, "R1 wraparound");
    op(32'h90, 16'h0004, 2'd3, 0, 1, 32'h0BADF00D, "R2 size3 as word");
    op(32'h94, 16'h0000, 2'd2, 0, 0, 32'h0, "R9 size3 readback");
    op(32'h94, 16'h0002, 2'd0, 0, 1, 32'h00000077, "R5 byte store off2");
    op(32'h94, 16'h0000, 2'd2, 0, 0, 32'h0, "R2 off2 lane");
    op(32'h94, 16'h0002, 2'd0, 0, 0, 32'h0, "R6 positive byte");

    @(negedge clk);
    store_i = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule